// File: doc/BRIEF.md
# Circular Buffer Pointer Stepper

This block advances an address pointer by a signed step and keeps the result inside a circular buffer. Each request carries the current pointer, the step, a modifier word that holds the buffer length and a size code, and a base-address word. The unit works out the buffer's lower and upper bounds and forms the raw sum of pointer and step. If the sum has left the buffer, it folds the sum back by one buffer length.

The bounds come from one of two schemes. When the size code is zero and the length is at least four, the buffer starts at the base-address word. Otherwise the buffer sits in a naturally aligned power-of-two window that the size code selects, and the pointer itself locates that window. The unit also returns the incoming pointer with its low half bit-reversed, for transform-style access patterns. A request is accepted on a cycle with `in_valid` high, and its results appear in registers one cycle later.

Top module: `circbuf_ptr_step`

## Requirements
- R1: The buffer length is modifier bits [16:0] and the 4-bit size code is modifier bits [27:24]. All other modifier bits have no effect on the result.
- R2: With size code 0 and length >= 4, the lower bound is the base word and the upper bound is base + length. This is explicit mode.
- R3: With a nonzero size code, or with length < 4, a mask of 2^(code+2)-1 is formed. The lower bound is the pointer with the mask bits cleared, and the upper bound is the lower bound ORed with the length. The base word is ignored. This is aligned mode.
- R4: The candidate is pointer + step, taken modulo 2^32.
- R5: If the candidate is >= the upper bound, the result is the candidate minus the length. This test has priority over R6.
- R6: Otherwise, if the candidate is below the lower bound, the result is the candidate plus the length.
- R7: Otherwise the result equals the candidate.
- R8: All bound comparisons are unsigned.
- R9: `rev_out` keeps bits [31:16] of the accepted pointer and holds its bits [15:0] in reversed order, with bit 0 moved to bit 15.
- R10: `out_valid` is high exactly one cycle after `in_valid`. While `in_valid` is low, `ptr_out` and `rev_out` hold their values.
- R11: After reset, `out_valid`, `ptr_out` and `rev_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| ptr_in | input | 32 | Current pointer |
| step_in | input | 32 | Signed step added to the pointer |
| modifier_in | input | 32 | Length and size-code word |
| base_in | input | 32 | Buffer base used in explicit mode |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| ptr_out | output | 32 | Updated pointer |
| rev_out | output | 32 | Pointer with its low half bit-reversed |

## Verification
On every cycle the assertions check the request-to-result latency and that results hold while idle. They also check that explicit mode takes its lower bound from the base word, that an in-range candidate passes through unchanged, that a downward fold happens only when the candidate has reached the upper bound, and that the upper half of the reversed output tracks the pointer. The bench's scenarios are what show the fold arithmetic itself. They cover hitting the exact upper and lower bounds, switching to aligned mode when a zero code comes with a length below four, the largest size code, unsigned comparison across the sign bit, and wrap of the raw sum past 2^32.

// File: rtl/circbuf_pkg.sv
package circbuf_pkg;

   // How the buffer bounds were chosen
   typedef enum logic {
      BND_EXPLICIT = 1'b0,
      BND_ALIGNED  = 1'b1
   } bnd_mode_e;

   // Which fold was applied to the candidate
   typedef enum logic [1:0] {
      FOLD_NONE = 2'd0,
      FOLD_DOWN = 2'd1,
      FOLD_UP   = 2'd2
   } fold_e;

endpackage

// File: rtl/circbuf_bounds.sv
module circbuf_bounds
   import circbuf_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LEN_W       = 17,
   parameter int KC_LSB      = 24,
   parameter int KC_W        = 4,
   parameter int MIN_EXP_LEN = 4,
   parameter bit KEEP_ALIGN  = 1'b1
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] modifier,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] len,
   output logic [AW-1:0] lo,
   output logic [AW-1:0] hi,
   output bnd_mode_e     mode
);
   localparam int SH_W     = KC_W + 1;
   localparam int MAX_SH   = (1 << KC_W) + 1;
   localparam logic [AW-1:0] FIELD_MASK =
      ({{(AW-LEN_W){1'b0}}, {LEN_W{1'b1}}}) |
      (AW'({KC_W{1'b1}}) << KC_LSB);

   if (LEN_W > KC_LSB) begin : g_bad_fields
      $error("length field overlaps size code");
   end
   if (KC_LSB + KC_W > AW) begin : g_bad_code
      $error("size code exceeds word");
   end
   if (MAX_SH >= AW) begin : g_bad_shift
      $error("alignment window exceeds word");
   end

   logic [KC_W-1:0] kc;
   logic [SH_W-1:0] shamt;
   logic [AW-1:0]   win_mask;
   logic [AW-1:0]   unused_mod;

   assign kc         = modifier[KC_LSB +: KC_W];
   assign len        = {{(AW-LEN_W){1'b0}}, modifier[LEN_W-1:0]};
   assign shamt      = {1'b0, kc} + SH_W'(2);
   assign win_mask   = ({{(AW-1){1'b0}}, 1'b1} << shamt) - {{(AW-1){1'b0}}, 1'b1};
   assign unused_mod = modifier & ~FIELD_MASK;

   if (KEEP_ALIGN) begin : g_two_mode
      always_comb begin
         if (kc == '0 && len >= AW'(MIN_EXP_LEN)) begin
            mode = BND_EXPLICIT;
            lo   = base;
            hi   = base + len;
         end else begin
            mode = BND_ALIGNED;
            lo   = ptr & ~win_mask;
            hi   = (ptr & ~win_mask) | len;
         end
      end
   end else begin : g_explicit_only
      logic unused_align;
      assign unused_align = ^{ptr, win_mask};
      assign mode = BND_EXPLICIT;
      assign lo   = base;
      assign hi   = base + len;
   end

endmodule

// File: rtl/circbuf_wrap.sv
module circbuf_wrap
   import circbuf_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] cand,
   output logic [AW-1:0] nxt,
   output fold_e         fold
);
   // Sum wraps at the word width; compares are unsigned vectors
   assign cand = ptr + step;

   always_comb begin
      if (cand >= hi) begin
         fold = FOLD_DOWN;
         nxt  = cand - len;
      end else if (cand < lo) begin
         fold = FOLD_UP;
         nxt  = cand + len;
      end else begin
         fold = FOLD_NONE;
         nxt  = cand;
      end
   end

endmodule

// File: rtl/circbuf_bitrev.sv
module circbuf_bitrev #(
   parameter int AW    = 32,
   parameter int REV_W = 16
) (
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] rev
);
   if (REV_W < 1 || REV_W > AW) begin : g_bad_rev
      $error("reverse width out of range");
   end

   for (genvar b = 0; b < REV_W; b++) begin : g_swap
      assign rev[b] = addr[REV_W-1-b];
   end
   if (REV_W < AW) begin : g_keep_top
      assign rev[AW-1:REV_W] = addr[AW-1:REV_W];
   end

endmodule

// File: rtl/circbuf_ptr_step.sv
module circbuf_ptr_step
   import circbuf_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LEN_W       = 17,
   parameter int KC_LSB      = 24,
   parameter int KC_W        = 4,
   parameter int MIN_EXP_LEN = 4,
   parameter int REV_W       = 16,
   parameter bit KEEP_ALIGN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [AW-1:0] ptr_in,
   input  logic [AW-1:0] step_in,
   input  logic [AW-1:0] modifier_in,
   input  logic [AW-1:0] base_in,
   output logic          out_valid,
   output logic [AW-1:0] ptr_out,
   output logic [AW-1:0] rev_out
);
   logic [AW-1:0] len, lo, hi, cand, nxt, rev;
   bnd_mode_e     mode;
   fold_e         fold;

   circbuf_bounds #(
      .AW(AW), .LEN_W(LEN_W), .KC_LSB(KC_LSB), .KC_W(KC_W),
      .MIN_EXP_LEN(MIN_EXP_LEN), .KEEP_ALIGN(KEEP_ALIGN)
   ) u_bounds (
      .ptr(ptr_in), .modifier(modifier_in), .base(base_in),
      .len(len), .lo(lo), .hi(hi), .mode(mode)
   );

   circbuf_wrap #(.AW(AW)) u_wrap (
      .ptr(ptr_in), .step(step_in), .len(len), .lo(lo), .hi(hi),
      .cand(cand), .nxt(nxt), .fold(fold)
   );

   circbuf_bitrev #(.AW(AW), .REV_W(REV_W)) u_rev (
      .addr(ptr_in), .rev(rev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ptr_out   <= '0;
         rev_out   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            ptr_out <= nxt;
            rev_out <= rev;
         end
      end
   end

   // Result strobe follows the request by one cycle
   p_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(ptr_out) && $stable(rev_out)));
   // Explicit mode must take its lower bound from the base word
   p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == BND_EXPLICIT) |-> (lo == base_in));
   // In-range candidate reaches the output untouched
   p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cand >= lo && cand < hi) |=> (ptr_out == $past(cand)));
   // A downward fold only when the upper bound was reached
   p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fold == FOLD_DOWN) |-> (cand >= hi));
   // Upper half of the reversed output follows the accepted pointer
   p_revtop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (rev_out[AW-1:REV_W] == $past(ptr_in[AW-1:REV_W])));

endmodule

// File: tb/sim_circbuf_ptr_step.sv
`timescale 1ns/1ps
module sim_circbuf_ptr_step;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] ptr_in = '0, step_in = '0, modifier_in = '0, base_in = '0;
   logic        out_valid;
   logic [31:0] ptr_out, rev_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   circbuf_ptr_step u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .ptr_in(ptr_in), .step_in(step_in), .modifier_in(modifier_in),
      .base_in(base_in), .out_valid(out_valid),
      .ptr_out(ptr_out), .rev_out(rev_out)
   );

   // Rows: {pointer, step, modifier, base, expected pointer}
   localparam logic [159:0] VEC [0:13] = '{
      {32'h00001010, 32'h00000010, 32'h00000100, 32'h00001000, 32'h00001020}, // R2 R7 inside
      {32'h000010F8, 32'h00000010, 32'h00000100, 32'h00001000, 32'h00001008}, // R5 past top
      {32'h00001004, 32'hFFFFFFF8, 32'h00000100, 32'h00001000, 32'h000010FC}, // R6 below base
      {32'h000010F0, 32'h00000010, 32'h00000100, 32'h00001000, 32'h00001000}, // R5 exactly top
      {32'h00001008, 32'hFFFFFFF8, 32'h00000100, 32'h00001000, 32'h00001000}, // R7 exactly bottom
      {32'h00002008, 32'h00000004, 32'h0200000C, 32'hDEAD0000, 32'h00002000}, // R3 aligned fold down
      {32'h00002002, 32'hFFFFFFFC, 32'h0200000C, 32'hDEAD0000, 32'h0000200A}, // R3 aligned fold up
      {32'h00003001, 32'h00000001, 32'h00000003, 32'h00000100, 32'h00003002}, // R3 code 0, len 3
      {32'h00003002, 32'h00000001, 32'h00000003, 32'h00000100, 32'h00003000}, // R3 code 0, len 3 fold
      {32'h800000F0, 32'h00000008, 32'h00000200, 32'h7FFFFF00, 32'h800000F8}, // R8 across sign bit
      {32'hFFFFFFF0, 32'h00000020, 32'h00000040, 32'h00000000, 32'h00000010}, // R4 sum wraps
      {32'h000010F8, 32'h00000010, 32'hF0FE0100, 32'h00001000, 32'h00001008}, // R1 stray bits
      {32'h0005FFF0, 32'h00000010, 32'h0F010000, 32'h00000000, 32'h00050000}, // R3 largest code
      {32'h00000503, 32'h00000001, 32'h00000004, 32'h00000500, 32'h00000500}  // R2 len exactly 4
   };

   function automatic logic [31:0] rev_low(input logic [31:0] a);
      logic [31:0] r;
      r = a;
      for (int b = 0; b < 16; b++) r[b] = a[15-b];
      return r;
   endfunction

   function automatic logic [31:0] ref_step(input logic [31:0] p, s, m, bs);
      logic [31:0] len, lo, hi, msk, c;
      len = {15'd0, m[16:0]};
      if (m[27:24] == 4'd0 && len >= 32'd4) begin
         lo = bs;
         hi = bs + len;
      end else begin
         msk = (32'd1 << (m[27:24] + 5'd2)) - 32'd1;
         lo  = p & ~msk;
         hi  = lo | len;
      end
      c = p + s;
      if (c >= hi)      c = c - len;
      else if (c < lo)  c = c + len;
      return c;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] p, s, m, bs);
      @(negedge clk);
      ptr_in = p; step_in = s; modifier_in = m; base_in = bs;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] hold_p, hold_r;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 out_valid", {31'd0, out_valid}, 32'd0);
      check("R11 ptr_out", ptr_out, 32'd0);
      check("R11 rev_out", rev_out, 32'd0);
      rst_n = 1'b1;

      // Table walk
      for (int i = 0; i < 14; i++) begin
         issue(VEC[i][159:128], VEC[i][127:96], VEC[i][95:64], VEC[i][63:32]);
         check($sformatf("R1-R8 row %0d", i), ptr_out, VEC[i][31:0]);
         check($sformatf("R9 row %0d", i), rev_out, rev_low(VEC[i][159:128]));
         check($sformatf("R10 valid row %0d", i), {31'd0, out_valid}, 32'd1);
      end

      // R10: idle cycle holds results while inputs change
      hold_p = ptr_out;
      hold_r = rev_out;
      ptr_in = 32'h12345678; step_in = 32'h11; modifier_in = 32'h100; base_in = 32'h0;
      @(negedge clk);
      check("R10 idle valid", {31'd0, out_valid}, 32'd0);
      check("R10 idle ptr hold", ptr_out, hold_p);
      check("R10 idle rev hold", rev_out, hold_r);

      // R9: distinct reversal pattern
      issue(32'hA5A50001, 32'd0, 32'h00000100, 32'hA5A50000);
      check("R9 pattern", rev_out, 32'hA5A58000);

      // R1..R8 against the reference model, mixed modes
      for (int n = 0; n < 300; n++) begin
         logic [31:0] p, s, m, bs, len, mag;
         len = 32'd1 + ($urandom % 32'h1FFFF);
         if (n % 3 == 0) m = {4'h0, 4'h0, 7'd0, len[16:0]};
         else if (n % 3 == 1) m = {4'h0, 4'($urandom), 7'd0, len[16:0]};
         else m = {4'h0, 4'h0, 7'd0, 17'($urandom % 4)};
         len = {15'd0, m[16:0]};
         bs  = $urandom;
         p   = (n % 3 == 0) ? bs + ($urandom % len) : $urandom;
         mag = (len == 0) ? 32'd0 : ($urandom % (len + 32'd1));
         s   = ($urandom % 2 == 0) ? mag : -mag;
         issue(p, s, m, bs);
         check($sformatf("R4-R8 random %0d", n), ptr_out, ref_step(p, s, m, bs));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule